// File: doc/BRIEF.md
# Shared Endpoint Buffer Pool Allocator

This block divides a pool of eight 512-byte RAM blocks among four data endpoints (indexed 0..3 here, standing for endpoints 2, 4, 6 and 8). A configuration code picks how many buffers each endpoint gets (two or four) and how large each packet buffer is (512 or 1024 bytes). Legal setups are either one choice for the first endpoint pair combined with one choice for the second pair, or one setup from a small set of whole-pool layouts. The fixed 64-byte control endpoint buffer sits outside this pool and is not handled here.

Blocks are handed out in a fixed order. The endpoints are laid out one after another in index order, starting at block 0. A 1024-byte buffer takes two adjacent blocks. For each endpoint the block keeps a fill pointer and a drain pointer. The fill pointer moves on when a packet is committed and the drain pointer moves on when a packet is released. The block reports full and empty per endpoint and gives the byte base address of the current fill buffer and of the current drain buffer. A code that is not a legal setup is refused: the running layout stays in place and an error flag is set.

Top module: `ep_pool_alloc`

## Requirements
- R1: After synchronous reset every endpoint is enabled with two 512-byte buffers. The direction vector is 4'b1100 (bit i = 1 means IN, so endpoints 2 and 3 are IN). Endpoint i uses blocks 2i and 2i+1. All endpoints are empty, all pointers are 0 and cfg_err is 0.
- R2: With cfg_sel[4]=0, field cfg_sel[1:0] sets endpoints 0/1 and field cfg_sel[3:2] sets endpoints 2/3. In each field, 0 gives both endpoints of the pair 512 bytes with two buffers. A value of 1 gives only the lower endpoint of the pair 512 bytes with four buffers. A value of 2 gives only the lower endpoint 1024 bytes with two buffers. A value of 3 is illegal.
- R3: With cfg_sel[4]=1, cfg_sel[3:0]=0 gives endpoint 0 alone 1024 bytes with four buffers (all eight blocks). cfg_sel[3:0]=1 gives endpoint 0 and endpoint 3 each 1024 bytes with two buffers. Any other value is illegal.
- R4: A cfg_load with an illegal code leaves the layout, pointers and directions unchanged and sets cfg_err. A cfg_load with a legal code clears cfg_err.
- R5: Enabled endpoints take blocks one after another in index order from block 0, and a 1024-byte buffer takes two adjacent blocks. A buffer's base byte address is 512 × (start block + buffer index × blocks per buffer). The pool never uses more than eight blocks.
- R6: A fill_done pulse that is accepted advances fill_idx by one, modulo the endpoint's buffer count. A drain_done pulse that is accepted does the same for drain_idx.
- R7: full is 1 when every buffer of an enabled endpoint holds a packet, and empty is 1 when none does. fill_done while full and drain_done while empty are ignored. Both pulses in the same cycle act on the occupancy from before that cycle.
- R8: A disabled endpoint ignores fill_done and drain_done. It shows empty=1, full=0, both indices 0 and both addresses 0.
- R9: An accepted cfg_load resets all pointers and occupancies to zero in the same clock and captures cfg_dir as the endpoint directions. Any fill_done or drain_done in that cycle is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_load | input | 1 | Apply cfg_sel and cfg_dir this cycle |
| cfg_sel | input | 5 | Layout code |
| cfg_dir | input | 4 | Per-endpoint direction, 1 = IN |
| fill_done | input | 4 | Per-endpoint packet commit pulse |
| drain_done | input | 4 | Per-endpoint packet release pulse |
| cfg_err | output | 1 | Last load was refused |
| ep_en | output | 4 | Endpoint has buffers in current layout |
| ep_dir | output | 4 | Endpoint direction, 1 = IN |
| full | output | 4 | All buffers occupied |
| empty | output | 4 | No buffer occupied |
| fill_idx | output | 8 | 2-bit fill index per endpoint |
| drain_idx | output | 8 | 2-bit drain index per endpoint |
| fill_addr | output | 48 | 12-bit fill buffer byte base per endpoint |
| drain_addr | output | 48 | 12-bit drain buffer byte base per endpoint |

## Verification
The hardest state to reach is an endpoint in a four-buffer 1024-byte layout that is completely full and then gets commit and release together, with the pointers already wrapped more than once. The same applies when a reload lands while packets are outstanding. Directed sequences fill each layout past its limit and drain it past empty, and then biased random traffic runs in every legal layout, with illegal loads mixed in. A behavioural occupancy model in the bench is compared against every output on every cycle.

// File: rtl/ep_pool_pkg.sv
package ep_pool_pkg;

    localparam int NUM_EP    = 4;
    localparam int NUM_BLK   = 8;
    localparam int BLK_BYTES = 512;
    localparam int BLK_W     = $clog2(NUM_BLK);
    localparam int OFS_W     = $clog2(BLK_BYTES);
    localparam int ADDR_W    = BLK_W + OFS_W;
    localparam int MAX_BUF   = 4;
    localparam int IDX_W     = $clog2(MAX_BUF);
    localparam int CNT_W     = $clog2(MAX_BUF + 1);
    localparam int TOT_W     = BLK_W + 2;
    localparam int SEL_W     = 5;
    localparam logic [NUM_EP-1:0] RST_DIR = 4'b1100;

    typedef enum logic [1:0] {
        PAIR_TWIN = 2'd0,
        PAIR_QUAD = 2'd1,
        PAIR_WIDE = 2'd2,
        PAIR_NONE = 2'd3
    } pair_mode_t;

    typedef struct packed {
        logic             en;
        logic             wide;
        logic             quad;
        logic [BLK_W-1:0] start;
    } ep_cfg_t;

    typedef ep_cfg_t [NUM_EP-1:0] ep_vec_t;

    typedef struct packed {
        logic    legal;
        ep_vec_t eps;
    } pool_cfg_t;

    function automatic logic [TOT_W-1:0] ep_blocks(ep_cfg_t c);
        logic [TOT_W-1:0] n;
        if (!c.en) begin
            n = '0;
        end else begin
            n = c.quad ? TOT_W'(4) : TOT_W'(2);
            if (c.wide) n = n << 1;
        end
        return n;
    endfunction

    function automatic logic [TOT_W-1:0] pool_usage(ep_vec_t v);
        logic [TOT_W-1:0] acc;
        acc = '0;
        for (int i = 0; i < NUM_EP; i++) acc = acc + ep_blocks(v[i]);
        return acc;
    endfunction

    function automatic ep_vec_t place_blocks(ep_vec_t v);
        ep_vec_t          r;
        logic [TOT_W-1:0] acc;
        r   = v;
        acc = '0;
        for (int i = 0; i < NUM_EP; i++) begin
            r[i].start = acc[BLK_W-1:0];
            acc        = acc + ep_blocks(r[i]);
        end
        return r;
    endfunction

    function automatic pool_cfg_t decode_sel(logic [SEL_W-1:0] sel);
        pool_cfg_t  r;
        pair_mode_t m;
        r       = '0;
        r.legal = 1'b1;
        if (!sel[SEL_W-1]) begin
            for (int p = 0; p < 2; p++) begin
                m = pair_mode_t'(sel[2*p +: 2]);
                case (m)
                    PAIR_TWIN: begin
                        r.eps[2*p].en   = 1'b1;
                        r.eps[2*p+1].en = 1'b1;
                    end
                    PAIR_QUAD: begin
                        r.eps[2*p].en   = 1'b1;
                        r.eps[2*p].quad = 1'b1;
                    end
                    PAIR_WIDE: begin
                        r.eps[2*p].en   = 1'b1;
                        r.eps[2*p].wide = 1'b1;
                    end
                    default: r.legal = 1'b0;
                endcase
            end
        end else begin
            case (sel[3:0])
                4'd0: begin
                    r.eps[0].en   = 1'b1;
                    r.eps[0].wide = 1'b1;
                    r.eps[0].quad = 1'b1;
                end
                4'd1: begin
                    r.eps[0].en   = 1'b1;
                    r.eps[0].wide = 1'b1;
                    r.eps[3].en   = 1'b1;
                    r.eps[3].wide = 1'b1;
                end
                default: r.legal = 1'b0;
            endcase
        end
        r.eps = place_blocks(r.eps);
        return r;
    endfunction

endpackage

// File: rtl/ep_cfg_reg.sv
module ep_cfg_reg
    import ep_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [SEL_W-1:0]  sel,
    input  logic [NUM_EP-1:0] dir_in,
    output ep_vec_t           cfg_q,
    output logic [NUM_EP-1:0] dir_q,
    output logic              err_q,
    output logic              accept
);

    localparam pool_cfg_t RST_CFG = decode_sel('0);

    pool_cfg_t dec;

    always_comb begin
        dec    = decode_sel(sel);
        accept = load && dec.legal;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= RST_CFG.eps;
            dir_q <= RST_DIR;
            err_q <= 1'b0;
        end else if (load) begin
            if (dec.legal) begin
                cfg_q <= dec.eps;
                dir_q <= dir_in;
                err_q <= 1'b0;
            end else begin
                err_q <= 1'b1;
            end
        end
    end

    AST_REJECT_KEEP: assert property (@(posedge clk) disable iff (rst)
        (load && !dec.legal) |=> ($stable(cfg_q) && $stable(dir_q) && err_q)); // R4

    AST_POOL_LIMIT: assert property (@(posedge clk) disable iff (rst)
        pool_usage(cfg_q) <= TOT_W'(NUM_BLK)); // R5

    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        accept |=> !err_q); // R4

endmodule

// File: rtl/ep_ring.sv
module ep_ring
    import ep_pool_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  ep_cfg_t           cfg,
    input  logic              fill_done,
    input  logic              drain_done,
    output logic [IDX_W-1:0]  fill_idx,
    output logic [IDX_W-1:0]  drain_idx,
    output logic              full,
    output logic              empty,
    output logic [ADDR_W-1:0] fill_addr,
    output logic [ADDR_W-1:0] drain_addr
);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] nbuf;
    logic [IDX_W-1:0] mask;
    logic             do_fill, do_drain;

    always_comb begin
        nbuf     = cfg.quad ? CNT_W'(MAX_BUF) : CNT_W'(2);
        mask     = cfg.quad ? IDX_W'(MAX_BUF - 1) : IDX_W'(1);
        do_fill  = cfg.en && fill_done  && (cnt != nbuf);
        do_drain = cfg.en && drain_done && (cnt != '0);
        full     = cfg.en && (cnt == nbuf);
        empty    = (cnt == '0);
    end

    function automatic logic [ADDR_W-1:0] buf_base(ep_cfg_t c, logic [IDX_W-1:0] idx);
        logic [BLK_W-1:0] blk;
        blk = c.start + (c.wide ? BLK_W'({idx, 1'b0}) : BLK_W'(idx));
        return c.en ? {blk, {OFS_W{1'b0}}} : '0;
    endfunction

    always_comb begin
        fill_addr  = buf_base(cfg, fill_idx);
        drain_addr = buf_base(cfg, drain_idx);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt       <= '0;
            fill_idx  <= '0;
            drain_idx <= '0;
        end else begin
            if (do_fill)  fill_idx  <= (fill_idx + 1'b1) & mask;
            if (do_drain) drain_idx <= (drain_idx + 1'b1) & mask;
            case ({do_fill, do_drain})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= nbuf); // R7

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (full && fill_done && !drain_done && !clear) |=> ($stable(fill_idx) && full)); // R7

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (empty && drain_done && !fill_done && !clear) |=> ($stable(drain_idx) && empty)); // R7

    AST_PTR_GAP: assert property (@(posedge clk) disable iff (rst)
        cfg.en |-> (((fill_idx - drain_idx) & mask) == (cnt[IDX_W-1:0] & mask))); // R6

    AST_IDLE_OFF: assert property (@(posedge clk) disable iff (rst)
        !cfg.en |-> (empty && !full && fill_idx == '0 && drain_idx == '0)); // R8

endmodule

// File: rtl/ep_pool_alloc.sv
module ep_pool_alloc
    import ep_pool_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_load,
    input  logic [SEL_W-1:0]              cfg_sel,
    input  logic [NUM_EP-1:0]             cfg_dir,
    input  logic [NUM_EP-1:0]             fill_done,
    input  logic [NUM_EP-1:0]             drain_done,
    output logic                          cfg_err,
    output logic [NUM_EP-1:0]             ep_en,
    output logic [NUM_EP-1:0]             ep_dir,
    output logic [NUM_EP-1:0]             full,
    output logic [NUM_EP-1:0]             empty,
    output logic [NUM_EP-1:0][IDX_W-1:0]  fill_idx,
    output logic [NUM_EP-1:0][IDX_W-1:0]  drain_idx,
    output logic [NUM_EP-1:0][ADDR_W-1:0] fill_addr,
    output logic [NUM_EP-1:0][ADDR_W-1:0] drain_addr
);

    ep_vec_t cfg_q;
    logic    accept;

    ep_cfg_reg u_cfg (
        .clk    (clk),
        .rst    (rst),
        .load   (cfg_load),
        .sel    (cfg_sel),
        .dir_in (cfg_dir),
        .cfg_q  (cfg_q),
        .dir_q  (ep_dir),
        .err_q  (cfg_err),
        .accept (accept)
    );

    for (genvar e = 0; e < NUM_EP; e++) begin : g_ep
        assign ep_en[e] = cfg_q[e].en;

        ep_ring u_ring (
            .clk        (clk),
            .rst        (rst),
            .clear      (accept),
            .cfg        (cfg_q[e]),
            .fill_done  (fill_done[e]),
            .drain_done (drain_done[e]),
            .fill_idx   (fill_idx[e]),
            .drain_idx  (drain_idx[e]),
            .full       (full[e]),
            .empty      (empty[e]),
            .fill_addr  (fill_addr[e]),
            .drain_addr (drain_addr[e])
        );
    end

    AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (rst)
        accept |=> (empty == '1 && fill_idx == '0 && drain_idx == '0)); // R9

    AST_FULL_EMPTY_EXCL: assert property (@(posedge clk) disable iff (rst)
        (full & empty) == '0); // R7

endmodule

// File: tb/ep_pool_alloc_tb_top.sv
module ep_pool_alloc_tb_top;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_load = 1'b0;
    logic [4:0]        cfg_sel = '0;
    logic [3:0]        cfg_dir = '0;
    logic [3:0]        fill_done = '0;
    logic [3:0]        drain_done = '0;
    logic              cfg_err;
    logic [3:0]        ep_en, ep_dir, full, empty;
    logic [3:0][1:0]   fill_idx, drain_idx;
    logic [3:0][11:0]  fill_addr, drain_addr;

    always #10 clk = ~clk;

    ep_pool_alloc dut_i (
        .clk(clk), .rst(rst), .cfg_load(cfg_load), .cfg_sel(cfg_sel),
        .cfg_dir(cfg_dir), .fill_done(fill_done), .drain_done(drain_done),
        .cfg_err(cfg_err), .ep_en(ep_en), .ep_dir(ep_dir), .full(full),
        .empty(empty), .fill_idx(fill_idx), .drain_idx(drain_idx),
        .fill_addr(fill_addr), .drain_addr(drain_addr)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // reference state
    int m_en[4], m_wide[4], m_quad[4], m_start[4];
    int m_fill[4], m_drain[4], m_cnt[4], m_dir[4];
    int m_err;
    bit after_reset, after_load;

    task automatic chk(input int got, input int exp, input string req, input string what);
        n_chk++;
        if (got != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // Requirement tables for R2 / R3, written as explicit cases
    task automatic ref_decode(input logic [4:0] s, output bit ok,
                              output int en[4], output int wd[4], output int qd[4]);
        for (int i = 0; i < 4; i++) begin en[i] = 0; wd[i] = 0; qd[i] = 0; end
        ok = 1;
        if (s[4]) begin
            if (s[3:0] == 4'd0) begin en[0] = 1; wd[0] = 1; qd[0] = 1; end
            else if (s[3:0] == 4'd1) begin en[0] = 1; wd[0] = 1; en[3] = 1; wd[3] = 1; end
            else ok = 0;
        end else begin
            for (int p = 0; p < 2; p++) begin
                int f = (p == 0) ? int'(s[1:0]) : int'(s[3:2]);
                if (f == 0) begin en[2*p] = 1; en[2*p+1] = 1; end
                else if (f == 1) begin en[2*p] = 1; qd[2*p] = 1; end
                else if (f == 2) begin en[2*p] = 1; wd[2*p] = 1; end
                else ok = 0;
            end
        end
    endtask

    task automatic ref_apply(input int en[4], input int wd[4], input int qd[4]);
        int acc = 0;
        for (int i = 0; i < 4; i++) begin
            m_en[i] = en[i]; m_wide[i] = wd[i]; m_quad[i] = qd[i];
            m_start[i] = acc;
            if (en[i] != 0) acc += (qd[i] != 0 ? 4 : 2) * (wd[i] != 0 ? 2 : 1);
            m_fill[i] = 0; m_drain[i] = 0; m_cnt[i] = 0;
        end
    endtask

    task automatic ref_reset();
        int en[4], wd[4], qd[4];
        bit ok;
        ref_decode(5'd0, ok, en, wd, qd);
        ref_apply(en, wd, qd);
        for (int i = 0; i < 4; i++) m_dir[i] = (i >= 2) ? 1 : 0;
        m_err = 0;
    endtask

    task automatic ref_clock();
        int en[4], wd[4], qd[4];
        bit ok;
        bit took = 0;
        after_load = 0;
        if (rst) begin ref_reset(); return; end
        if (cfg_load) begin
            ref_decode(cfg_sel, ok, en, wd, qd);
            if (ok) begin
                ref_apply(en, wd, qd);
                for (int i = 0; i < 4; i++) m_dir[i] = int'(cfg_dir[i]);
                m_err = 0; took = 1; after_load = 1;
            end else m_err = 1;
        end
        if (!took) begin
            for (int i = 0; i < 4; i++) begin
                int nb = (m_quad[i] != 0) ? 4 : 2;
                bit f = (m_en[i] != 0) && fill_done[i]  && (m_cnt[i] < nb);
                bit d = (m_en[i] != 0) && drain_done[i] && (m_cnt[i] > 0);
                if (f) begin m_fill[i]  = (m_fill[i] + 1) % nb;  m_cnt[i]++; end
                if (d) begin m_drain[i] = (m_drain[i] + 1) % nb; m_cnt[i]--; end
            end
        end
    endtask

    function automatic int ref_addr(int i, int idx);
        if (m_en[i] == 0) return 0;
        return (m_start[i] + idx * (m_wide[i] != 0 ? 2 : 1)) * 512;
    endfunction

    task automatic compare_all();
        string rq;
        chk(int'(cfg_err), m_err, after_reset ? "R1" : "R4", "cfg_err");
        for (int i = 0; i < 4; i++) begin
            int nb = (m_quad[i] != 0) ? 4 : 2;
            string live = after_reset ? "R1" : "";
            rq = (live != "") ? live : (m_en[i] != 0 ? "R6" : "R8");
            if (after_load) rq = "R9";
            chk(int'(ep_en[i]), m_en[i], after_reset ? "R1" : (cfg_sel[4] ? "R3" : "R2"), $sformatf("ep_en[%0d]", i));
            chk(int'(ep_dir[i]), m_dir[i], after_reset ? "R1" : "R9", $sformatf("ep_dir[%0d]", i));
            chk(int'(fill_idx[i]), m_fill[i], rq, $sformatf("fill_idx[%0d]", i));
            chk(int'(drain_idx[i]), m_drain[i], rq, $sformatf("drain_idx[%0d]", i));
            rq = (live != "") ? live : (m_en[i] != 0 ? "R7" : "R8");
            chk(int'(full[i]), (m_en[i] != 0 && m_cnt[i] == nb) ? 1 : 0, rq, $sformatf("full[%0d]", i));
            chk(int'(empty[i]), (m_cnt[i] == 0) ? 1 : 0, rq, $sformatf("empty[%0d]", i));
            rq = (live != "") ? live : (m_en[i] != 0 ? "R5" : "R8");
            chk(int'(fill_addr[i]), ref_addr(i, m_fill[i]), rq, $sformatf("fill_addr[%0d]", i));
            chk(int'(drain_addr[i]), ref_addr(i, m_drain[i]), rq, $sformatf("drain_addr[%0d]", i));
        end
    endtask

    task automatic cyc(input bit ld, input logic [4:0] s, input logic [3:0] dr,
                       input logic [3:0] f, input logic [3:0] d);
        cfg_load = ld; cfg_sel = s; cfg_dir = dr; fill_done = f; drain_done = d;
        @(posedge clk);
        ref_clock();
        after_reset = 0;
        @(negedge clk);
        compare_all();
        cfg_load = 0; fill_done = '0; drain_done = '0;
    endtask

    task automatic load_cfg(input logic [4:0] s, input logic [3:0] dr);
        cyc(1'b1, s, dr, 4'hF, 4'hF); // pulses in the load cycle are discarded (R9)
    endtask

    task automatic random_run(input int n, input int fill_pct, input int drain_pct);
        for (int k = 0; k < n; k++) begin
            logic [3:0] f, d;
            for (int i = 0; i < 4; i++) begin
                f[i] = ($urandom_range(99) < fill_pct);
                d[i] = ($urandom_range(99) < drain_pct);
            end
            if ($urandom_range(99) < 3)
                cyc(1'b1, 5'($urandom_range(31)), 4'($urandom_range(15)), f, d);
            else
                cyc(1'b0, cfg_sel, '0, f, d);
        end
    endtask

    initial begin
        ref_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        after_reset = 1;
        compare_all(); // R1 reset state

        // R7: fill endpoint 0 past full, then drain past empty
        for (int k = 0; k < 4; k++) cyc(1'b0, 5'd0, '0, 4'b0001, '0);
        for (int k = 0; k < 4; k++) cyc(1'b0, 5'd0, '0, '0, 4'b0001);
        // simultaneous commit and release while full and while empty
        cyc(1'b0, 5'd0, '0, 4'b0010, '0);
        cyc(1'b0, 5'd0, '0, 4'b0010, '0);
        cyc(1'b0, 5'd0, '0, 4'b0010, 4'b0010);
        cyc(1'b0, 5'd0, '0, 4'b0100, 4'b0100);

        // R4: illegal codes keep the layout
        cyc(1'b1, 5'b00011, 4'b1111, '0, '0);
        cyc(1'b1, 5'b01100, 4'b1111, 4'b1111, '0);
        cyc(1'b1, 5'b10010, 4'b0000, '0, '0);
        cyc(1'b1, 5'b11111, 4'b0000, '0, 4'b1111);

        // R3: whole pool to endpoint 0, four 1024-byte buffers
        load_cfg(5'b10000, 4'b0001);
        for (int k = 0; k < 6; k++) cyc(1'b0, cfg_sel, '0, 4'b1111, '0);
        for (int k = 0; k < 9; k++) cyc(1'b0, cfg_sel, '0, 4'b1111, 4'b1111);
        for (int k = 0; k < 6; k++) cyc(1'b0, cfg_sel, '0, '0, 4'b1111);
        // reload while packets outstanding (R9)
        for (int k = 0; k < 3; k++) cyc(1'b0, cfg_sel, '0, 4'b1111, '0);
        load_cfg(5'b10001, 4'b1000);

        // R2 combinations and random traffic in each legal layout
        begin
            logic [4:0] lay [10] = '{5'b00000, 5'b00101, 5'b01010, 5'b00110,
                                    5'b01001, 5'b00010, 5'b01000, 5'b00001,
                                    5'b10000, 5'b10001};
            for (int j = 0; j < 10; j++) begin
                load_cfg(lay[j], 4'($urandom_range(15)));
                random_run(120, 70, 30);
                random_run(120, 30, 70);
                random_run(80, 90, 90);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
            $finish;
        end
    end

endmodule